// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block keeps track of which of four power modes the chip is in and turns that mode into enable signals for the controllable subsystems, the two clock domains and the regulator. In order of falling power draw, the modes are active, alternate active, sleep and hibernate. Software writes a mode request into a small register port. The sequencer accepts the request only if it meets the entry conditions. Two template registers give the subsystem enables for the two running modes. The two low modes switch every subsystem off, whatever the templates hold.

Each low mode accepts its own set of wake events and reset requests. A permitted wake event in sleep or hibernate does not restore the enables at once. First a programmable settling counter runs out, and only then does the mode return to active. Alternate active goes back to active as soon as any interrupt or wake event arrives. A cause register records the event that caused the last wakeup and holds it until software clears it.

Top module: `pwr_mode_seq`

## Requirements
- R1: After synchronous reset the state is as follows. Mode is 00. `sub_en` equals the active template reset value, all ones. Both clocks are enabled. `reg_state` is 00. `waking_o` is 0 and `wake_cause` is 0. The sleep delay is 20 and the hibernate delay is 100.
- R2: `mode_o` encodes the mode as 00 active, 01 alternate active, 10 sleep and 11 hibernate. A write to address 0 requests the mode held in data[1:0]. The mode changes on the next edge when the current mode is 00 or 01. A write to address 0 has no effect while the mode is 10 or 11.
- R3: In mode 00, `sub_en` equals the template written at address 1. In mode 01, it equals the template written at address 2. A template write shows on `sub_en` in the cycle after the write.
- R4: In modes 10 and 11, `sub_en` is all zeros, whatever the templates hold.
- R5: A request for mode 10 or 11 is refused unless every bit of `supply_ok` is 1. A refused request leaves the mode unchanged.
- R6: Clock and regulator outputs depend on the mode. Modes 00 and 01 give hf=1, lf=1 and reg_state 00 (full). Mode 10 gives hf=0, lf=1 and reg_state 01 (reduced). Mode 11 gives hf=0, lf=0 and reg_state 10 (retention only). These values stay in place during the wake delay.
- R7: The bits of `wake_evt` are: 0 general interrupt, 1 comparator, 2 pin interrupt, 3 I2C address match, 4 real-time clock tick, 5 periodic wake timer, 6 low-voltage detect. Sleep wakes on bits 1 to 6. Hibernate wakes on bit 2 only. Any other bit leaves the low mode unchanged.
- R8: In mode 01, any set bit of `wake_evt` returns the mode to 00 on the next edge.
- R9: Suppose a permitted wake event is taken at edge t in a low mode. Then `waking_o` is 1 from edge t, and the mode becomes 00 at edge t+D+1. D is the delay at address 3 for sleep or address 4 for hibernate. Wake events seen while `waking_o` is 1 are ignored.
- R10: The bits of `rst_req` are: 0 external, 1 low-voltage detect, 2 watchdog, 3 software. Modes 00 and 01 accept all four. Sleep accepts bits 0 to 2. Hibernate accepts bit 0 only. An accepted request sets the mode to 00 on the next edge and cancels a wake delay in progress. An accepted reset takes precedence over a wake event, and a wake event over a mode write. A refused reset request has no effect.
- R11: A sleep or hibernate request is aborted, with the mode unchanged, when a wake event permitted for the target mode is present in the same cycle.
- R12: A wakeup from mode 01, 10 or 11 loads `wake_cause` with the permitted wake bits seen at that edge. A write to address 5 clears the `wake_cause` bits that are set in data[6:0]. A new wakeup in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Register write data |
| wake_evt | input | 7 | Wake event vector |
| rst_req | input | 4 | Reset request vector |
| supply_ok | input | N_IO | IO supply-good flags |
| sub_en | output | N_SUB | Subsystem enables |
| hf_clk_en | output | 1 | High-speed clock enable |
| lf_clk_en | output | 1 | Low-speed clock enable |
| reg_state | output | 2 | Regulator state |
| mode_o | output | 2 | Current mode |
| waking_o | output | 1 | Wake delay in progress |
| wake_cause | output | 7 | Cause of most recent wakeup |

## Verification
The bench targets several corner cases, and each has a clear symptom when the design is wrong.

- **Entry with a wake event in the same cycle.** A wake event that is permitted for the target mode must abort the entry, while one that is not permitted must not. A design that checks the current mode's whitelist instead of the target's would either fall asleep while a comparator is firing, or refuse to sleep because of an ordinary interrupt.
- **Wake delay length.** The delay is measured edge by edge, both with the reset default and with programmed values. A design that is off by one would restore the enables one cycle early or late.
- **Precedence.** The bench checks that a watchdog reset cuts a wake delay short, that a reset takes precedence over an alternate-active wake event and leaves the cause untouched, and that a new wakeup takes precedence over a cause clear in the same cycle. A design with the wrong ordering would log a stale cause or stay stuck in a low mode.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [1:0] {
        MODE_ACT   = 2'b00,
        MODE_ALT   = 2'b01,
        MODE_SLEEP = 2'b10,
        MODE_HIB   = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        REG_FULL    = 2'b00,
        REG_REDUCED = 2'b01,
        REG_RETAIN  = 2'b10
    } regst_e;

    typedef struct packed {
        logic   hf;
        logic   lf;
        regst_e rs;
    } clkreg_t;

    localparam int WAKE_N = 7;
    localparam int RST_N  = 4;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TACT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TALT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DSLP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DHIB  = 3'd4;
    localparam logic [ADDR_W-1:0] A_WCLR  = 3'd5;

    function automatic logic is_low(pmode_e m);
        return m == MODE_SLEEP || m == MODE_HIB;
    endfunction

    function automatic logic [WAKE_N-1:0] wake_allow(pmode_e m);
        case (m)
            MODE_ALT:   return '1;
            MODE_SLEEP: return 7'b111_1110;
            MODE_HIB:   return 7'b000_0100;
            default:    return '0;
        endcase
    endfunction

    function automatic logic [RST_N-1:0] rst_allow(pmode_e m);
        case (m)
            MODE_SLEEP: return 4'b0111;
            MODE_HIB:   return 4'b0001;
            default:    return 4'b1111;
        endcase
    endfunction

    function automatic clkreg_t clkreg_of(pmode_e m);
        clkreg_t c;
        case (m)
            MODE_SLEEP: c = '{hf: 1'b0, lf: 1'b1, rs: REG_REDUCED};
            MODE_HIB:   c = '{hf: 1'b0, lf: 1'b0, rs: REG_RETAIN};
            default:    c = '{hf: 1'b1, lf: 1'b1, rs: REG_FULL};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pms_regfile.sv
module pms_regfile
    import pms_pkg::*;
#(
    parameter int N_SUB   = 8,
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 16,
    parameter int SLP_DLY = 20,
    parameter int HIB_DLY = 100
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   cause_set,
    input  logic [WAKE_N-1:0]      cause_val,
    output logic [N_SUB-1:0]       tmpl_act,
    output logic [N_SUB-1:0]       tmpl_alt,
    output logic [CNT_W-1:0]       dly_slp,
    output logic [CNT_W-1:0]       dly_hib,
    output logic [WAKE_N-1:0]      cause
);

    logic [1:0][N_SUB-1:0] tmpl_w;
    logic [1:0][CNT_W-1:0] dly_w;
    logic [WAKE_N-1:0]     cause_q;

    // index 0 serves the active mode / sleep, index 1 alternate / hibernate
    for (genvar g = 0; g < 2; g++) begin : g_set
        localparam logic [ADDR_W-1:0] T_SEL  = (g == 0) ? A_TACT : A_TALT;
        localparam logic [ADDR_W-1:0] D_SEL  = (g == 0) ? A_DSLP : A_DHIB;
        localparam logic [N_SUB-1:0]  T_INIT = (g == 0) ? {N_SUB{1'b1}} : {N_SUB{1'b0}};
        localparam logic [CNT_W-1:0]  D_INIT = (g == 0) ? CNT_W'(SLP_DLY) : CNT_W'(HIB_DLY);

        logic [N_SUB-1:0] t_q;
        logic [CNT_W-1:0] d_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                t_q <= T_INIT;
                d_q <= D_INIT;
            end else if (wr_en) begin
                if (wr_addr == T_SEL) t_q <= wr_data[N_SUB-1:0];
                if (wr_addr == D_SEL) d_q <= wr_data[CNT_W-1:0];
            end
        end

        assign tmpl_w[g] = t_q;
        assign dly_w[g]  = d_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cause_q <= '0;
        else if (cause_set)
            cause_q <= cause_val;
        else if (wr_en && wr_addr == A_WCLR)
            cause_q <= cause_q & ~wr_data[WAKE_N-1:0];
    end

    assign tmpl_act = tmpl_w[0];
    assign tmpl_alt = tmpl_w[1];
    assign dly_slp  = dly_w[0];
    assign dly_hib  = dly_w[1];
    assign cause    = cause_q;

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
    import pms_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  pmode_e            req_mode,
    input  logic [WAKE_N-1:0] wake,
    input  logic [RST_N-1:0]  rst_req,
    input  logic              supply_good,
    input  logic [CNT_W-1:0]  dly_slp,
    input  logic [CNT_W-1:0]  dly_hib,
    output pmode_e            mode,
    output logic              waking,
    output logic              cause_set,
    output logic [WAKE_N-1:0] cause_val
);

    pmode_e            mode_q, mode_n;
    logic              wk_q, wk_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              rst_hit, wake_hit, entry_ok;

    always_comb begin
        rst_hit   = |(rst_req & rst_allow(mode_q));
        wake_hit  = !wk_q && (|(wake & wake_allow(mode_q)));
        entry_ok  = is_low(req_mode)
                  ? (supply_good && !(|(wake & wake_allow(req_mode))))
                  : 1'b1;
        cause_val = wake & wake_allow(mode_q);

        mode_n    = mode_q;
        wk_n      = wk_q;
        cnt_n     = cnt_q;
        cause_set = 1'b0;

        if (rst_hit) begin
            mode_n = MODE_ACT;
            wk_n   = 1'b0;
            cnt_n  = '0;
        end else if (wk_q) begin
            if (cnt_q == '0) begin
                mode_n = MODE_ACT;
                wk_n   = 1'b0;
            end else begin
                cnt_n = cnt_q - 1'b1;
            end
        end else if (wake_hit) begin
            cause_set = 1'b1;
            if (mode_q == MODE_ALT) begin
                mode_n = MODE_ACT;
            end else begin
                wk_n  = 1'b1;
                cnt_n = (mode_q == MODE_SLEEP) ? dly_slp : dly_hib;
            end
        end else if (req_valid && !is_low(mode_q) && entry_ok) begin
            mode_n = req_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_ACT;
            wk_q   <= 1'b0;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_n;
            wk_q   <= wk_n;
            cnt_q  <= cnt_n;
        end
    end

    assign mode   = mode_q;
    assign waking = wk_q;

endmodule

// File: rtl/pms_outmap.sv
module pms_outmap
    import pms_pkg::*;
#(
    parameter int N_SUB = 8
) (
    input  pmode_e           mode,
    input  logic [N_SUB-1:0] tmpl_act,
    input  logic [N_SUB-1:0] tmpl_alt,
    output logic [N_SUB-1:0] sub_en,
    output logic             hf_clk_en,
    output logic             lf_clk_en,
    output regst_e           reg_state
);

    logic    in_act, in_alt;
    clkreg_t cr;

    assign in_act = (mode == MODE_ACT);
    assign in_alt = (mode == MODE_ALT);

    for (genvar i = 0; i < N_SUB; i++) begin : g_sub
        assign sub_en[i] = (in_act & tmpl_act[i]) | (in_alt & tmpl_alt[i]);
    end

    assign cr        = clkreg_of(mode);
    assign hf_clk_en = cr.hf;
    assign lf_clk_en = cr.lf;
    assign reg_state = cr.rs;

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int N_SUB   = 8,
    parameter int N_IO    = 4,
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 16,
    parameter int SLP_DLY = 20,
    parameter int HIB_DLY = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [6:0]        wake_evt,
    input  logic [3:0]        rst_req,
    input  logic [N_IO-1:0]   supply_ok,
    output logic [N_SUB-1:0]  sub_en,
    output logic              hf_clk_en,
    output logic              lf_clk_en,
    output logic [1:0]        reg_state,
    output logic [1:0]        mode_o,
    output logic              waking_o,
    output logic [6:0]        wake_cause
);

    pmode_e            mode;
    regst_e            rs;
    logic              waking;
    logic              cause_set;
    logic [WAKE_N-1:0] cause_val;
    logic [N_SUB-1:0]  tmpl_act, tmpl_alt;
    logic [CNT_W-1:0]  dly_slp, dly_hib;
    logic              req_valid;

    assign req_valid = wr_en && (wr_addr == A_MODE);

    pms_regfile #(
        .N_SUB(N_SUB), .CNT_W(CNT_W), .DATA_W(DATA_W),
        .SLP_DLY(SLP_DLY), .HIB_DLY(HIB_DLY)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cause_set (cause_set),
        .cause_val (cause_val),
        .tmpl_act  (tmpl_act),
        .tmpl_alt  (tmpl_alt),
        .dly_slp   (dly_slp),
        .dly_hib   (dly_hib),
        .cause     (wake_cause)
    );

    pms_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_mode    (pmode_e'(wr_data[1:0])),
        .wake        (wake_evt),
        .rst_req     (rst_req),
        .supply_good (&supply_ok),
        .dly_slp     (dly_slp),
        .dly_hib     (dly_hib),
        .mode        (mode),
        .waking      (waking),
        .cause_set   (cause_set),
        .cause_val   (cause_val)
    );

    pms_outmap #(.N_SUB(N_SUB)) u_map (
        .mode      (mode),
        .tmpl_act  (tmpl_act),
        .tmpl_alt  (tmpl_alt),
        .sub_en    (sub_en),
        .hf_clk_en (hf_clk_en),
        .lf_clk_en (lf_clk_en),
        .reg_state (rs)
    );

    assign reg_state = rs;
    assign mode_o    = mode;
    assign waking_o  = waking;

endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
    parameter int N_SUB = 8,
    parameter int N_IO  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_IO-1:0]  supply_ok,
    input logic [6:0]       wake_evt,
    input logic             rst_ext,
    input logic [1:0]       mode_o,
    input logic [N_SUB-1:0] sub_en,
    input logic             hf_clk_en,
    input logic             lf_clk_en,
    input logic [1:0]       reg_state,
    input logic             waking
);

    assert_low_all_off_R4: assert property (@(posedge clk) disable iff (rst)
        mode_o[1] |-> (sub_en == '0));

    assert_supply_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !mode_o[1] |=> (!mode_o[1] || $past(&supply_ok)));

    assert_sleep_clocks_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> (!hf_clk_en && lf_clk_en && reg_state == 2'b01));

    assert_hib_clocks_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b11) |-> (!hf_clk_en && !lf_clk_en && reg_state == 2'b10));

    assert_alt_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b01 && (|wake_evt)) |=> (mode_o == 2'b00));

    assert_hib_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b11 && !waking && !rst_ext) |=> (mode_o == 2'b11));

    assert_wake_blank_R9: assert property (@(posedge clk) disable iff (rst)
        waking |-> (sub_en == '0 && !hf_clk_en && mode_o[1]));

endmodule

bind pwr_mode_seq pms_checker #(.N_SUB(N_SUB), .N_IO(N_IO)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .wake_evt  (wake_evt),
    .rst_ext   (rst_req[0]),
    .mode_o    (mode_o),
    .sub_en    (sub_en),
    .hf_clk_en (hf_clk_en),
    .lf_clk_en (lf_clk_en),
    .reg_state (reg_state),
    .waking    (waking_o)
);

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [6:0]  wake = '0;
    logic [3:0]  rstq = '0;
    logic [3:0]  sup = 4'hF;

    logic [7:0]  sub_en;
    logic        hf, lf, waking;
    logic [1:0]  reg_state, mode;
    logic [6:0]  cause;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    pwr_mode_seq u_pwr_mode_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wake_evt(wake), .rst_req(rstq), .supply_ok(sup),
        .sub_en(sub_en), .hf_clk_en(hf), .lf_clk_en(lf), .reg_state(reg_state),
        .mode_o(mode), .waking_o(waking), .wake_cause(cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_mode, m_wk, m_cnt, m_cause, m_tact, m_talt, m_dslp, m_dhib;

    function automatic int wmask(int m);
        case (m)
            1: return 'h7F;
            2: return 'h7E;
            3: return 'h04;
            default: return 0;
        endcase
    endfunction

    function automatic int rmask(int m);
        case (m)
            2: return 'h7;
            3: return 'h1;
            default: return 'hF;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int nm, nw, nc, ncause, tgt;
        if (rst) begin
            m_mode = 0; m_wk = 0; m_cnt = 0; m_cause = 0;
            m_tact = 'hFF; m_talt = 0; m_dslp = 20; m_dhib = 100;
        end else begin
            nm = m_mode; nw = m_wk; nc = m_cnt; ncause = m_cause;
            if (wr_en && wr_addr == 5) ncause = m_cause & ~int'(wr_data[6:0]);
            if ((int'(rstq) & rmask(m_mode)) != 0) begin
                nm = 0; nw = 0; nc = 0;
            end else if (m_wk != 0) begin
                if (m_cnt == 0) begin nm = 0; nw = 0; end
                else nc = m_cnt - 1;
            end else if ((int'(wake) & wmask(m_mode)) != 0) begin
                ncause = int'(wake) & wmask(m_mode);
                if (m_mode == 1) nm = 0;
                else begin nw = 1; nc = (m_mode == 2) ? m_dslp : m_dhib; end
            end else if (wr_en && wr_addr == 0 && m_mode < 2) begin
                tgt = int'(wr_data[1:0]);
                if (tgt < 2) nm = tgt;
                else if ((&sup) && (int'(wake) & wmask(tgt)) == 0) nm = tgt;
            end
            if (wr_en && wr_addr == 1) m_tact = int'(wr_data[7:0]);
            if (wr_en && wr_addr == 2) m_talt = int'(wr_data[7:0]);
            if (wr_en && wr_addr == 3) m_dslp = int'(wr_data);
            if (wr_en && wr_addr == 4) m_dhib = int'(wr_data);
            m_mode = nm; m_wk = nw; m_cnt = nc; m_cause = ncause;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 model mode", int'(mode), m_mode);
            chk("R3 model sub_en", int'(sub_en),
                (m_mode == 0) ? m_tact : (m_mode == 1) ? m_talt : 0);
            chk("R6 model hf", int'(hf), (m_mode < 2) ? 1 : 0);
            chk("R6 model lf", int'(lf), (m_mode < 3) ? 1 : 0);
            chk("R6 model reg_state", int'(reg_state), (m_mode < 2) ? 0 : m_mode - 1);
            chk("R9 model waking", int'(waking), m_wk);
            chk("R12 model cause", int'(cause), m_cause);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            checks++; fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] w, input logic [3:0] r);
        wake = w; rstq = r;
        @(negedge clk);
        wake = '0; rstq = '0;
    endtask

    task automatic combo(input logic [2:0] a, input logic [15:0] d, input logic [6:0] w);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wake = w;
        @(negedge clk);
        wr_en = 1'b0; wake = '0;
    endtask

    task automatic count_wake(input string tag, input int exp);
        int n = 0;
        while (mode != 2'b00 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(tag, n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 mode", int'(mode), 0);
        chk("R1 sub_en", int'(sub_en), 'hFF);
        chk("R1 clocks", int'({hf, lf}), 3);
        chk("R1 reg_state", int'(reg_state), 0);
        chk("R1 waking", int'(waking), 0);
        chk("R1 cause", int'(cause), 0);

        wr(3'd1, 16'h00A5);
        chk("R3 active template", int'(sub_en), 'hA5);
        wr(3'd2, 16'h003C);
        wr(3'd0, 16'd1);
        chk("R2 enter alternate", int'(mode), 1);
        chk("R3 alternate template", int'(sub_en), 'h3C);

        pulse(7'h01, 4'h0);
        chk("R8 alternate exit", int'(mode), 0);
        chk("R12 cause from interrupt", int'(cause), 'h01);
        wr(3'd5, 16'h0001);
        chk("R12 cause cleared", int'(cause), 0);

        sup = 4'b1011;
        wr(3'd0, 16'd2);
        chk("R5 refused without supply", int'(mode), 0);
        sup = 4'hF;

        combo(3'd0, 16'd2, 7'h02);
        chk("R11 entry aborted by comparator", int'(mode), 0);
        combo(3'd0, 16'd2, 7'h01);
        chk("R7 interrupt does not block sleep", int'(mode), 2);
        chk("R4 sleep enables off", int'(sub_en), 0);
        chk("R6 sleep clocks", int'({hf, lf, reg_state}), 'b0101);

        wr(3'd0, 16'd0);
        chk("R2 write ignored in sleep", int'(mode), 2);
        pulse(7'h01, 4'h8);
        chk("R7 interrupt ignored in sleep", int'(mode), 2);
        chk("R10 software reset refused in sleep", int'(waking), 0);

        pulse(7'h10, 4'h0);
        count_wake("R9 default sleep delay", 21);
        chk("R12 cause rtc", int'(cause), 'h10);

        wr(3'd3, 16'd5);
        wr(3'd4, 16'd3);
        wr(3'd0, 16'd3);
        chk("R6 hibernate clocks", int'({hf, lf, reg_state}), 'b0010);
        pulse(7'h02, 4'h2);
        chk("R7 comparator ignored in hibernate", int'(mode), 3);
        chk("R10 lvd reset refused in hibernate", int'(waking), 0);
        pulse(7'h04, 4'h0);
        count_wake("R9 hibernate delay", 4);
        chk("R12 cause pin", int'(cause), 'h04);

        wr(3'd0, 16'd2);
        pulse(7'h08, 4'h0);
        @(negedge clk);
        chk("R9 waking during delay", int'(waking), 1);
        pulse(7'h00, 4'h4);
        chk("R10 watchdog cuts delay", int'(mode), 0);
        chk("R10 waking cleared", int'(waking), 0);

        wr(3'd0, 16'd1);
        combo(3'd5, 16'h007F, 7'h20);
        chk("R12 set beats clear", int'(cause), 'h20);
        chk("R8 exit on timer", int'(mode), 0);

        wr(3'd0, 16'd1);
        pulse(7'h01, 4'h8);
        chk("R10 reset over wake mode", int'(mode), 0);
        chk("R10 reset leaves cause", int'(cause), 'h20);

        wr(3'd0, 16'd3);
        pulse(7'h00, 4'h1);
        chk("R10 external reset in hibernate", int'(mode), 0);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule